// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block belongs to a 16-bit processor core. At each instruction boundary it decides whether an interrupt is taken and which one. The execution unit reports each finished instruction with a one-cycle `instrDone` pulse. With that pulse come the internal causes of the instruction: a divide fault, a software interrupt with its type, an overflow-check instruction, or a return-from-interrupt instruction. The sequencer also watches an edge-sensitive non-maskable pin and a level-sensitive maskable request pin, and it keeps a single-step arming bit. The block owns the flag word and the stack pointer. The execution unit supplies the current code segment, the address of the next instruction and the stack segment.

When an interrupt is accepted, the block pushes three words onto the stack through a single memory port, clears the interrupt-enable and trap flags, and fetches a two-word vector from a table at the bottom of memory. It then pulses `redirect` together with the new code segment and instruction pointer. The return sequence pops the same three words and redirects back to the interrupted code. The memory port is a single port with a read latency of one cycle.

Top module: `int_entry_seq`

## Requirements
- R1: After reset the flag word is 0x0000, so the interrupt-enable flag is off. The block is idle, makes no memory request and does not redirect.
- R2: Interrupt causes are evaluated only in a cycle where `instrDone` is high while the block is idle. A pending request with no boundary starts no sequence and makes no memory access.
- R3: Entry writes three 16-bit words at physical address `ssBase*16 + SP`, decrementing SP by 2 before each write. The order is the flag word, then `curCs`, then `nextIp`.
- R4: Once the flag word has been pushed, bit 9 (interrupt enable) and bit 8 (trap) of `flagsOut` are 0 for the rest of the entry.
- R5: For type n the block reads the IP from physical address n*4 and the CS from n*4+2. It then pulses `redirect` for one cycle with those two words on `newCs` and `newIp`.
- R6: The boundary cause is chosen by fixed priority: divide fault (type 0), then software interrupt (its own type 0–255), then overflow check (type 4), then the non-maskable request (type 2), then the maskable request (type from `intrType`), then single step (type 1).
- R7: A low-to-high edge on `nmiPin` is held pending until its entry starts, whatever the interrupt-enable flag is. Keeping the pin high does not raise a second request.
- R8: The maskable request is a level and is taken only while flag bit 9 is 1.
- R9: The overflow check raises type 4 only when flag bit 11 is 1. Otherwise it starts nothing.
- R10: Return reads IP, then CS, then the flag word from `ssBase*16 + SP`, adding 2 to SP after each read. It then redirects to the popped CS and IP with the popped flags restored.
- R11: If a non-maskable edge is pending when an entry finishes, a second entry of type 2 starts straight away. Its pushed return address is the first handler's vector.
- R12: Single step (type 1) is raised at a boundary only if flag bit 8 was already 1 when the instruction that just finished began.
- R13: Writes to the flag word or SP from the execution unit are ignored while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | One-cycle pulse: an instruction has completed |
| divErr | input | 1 | Completed instruction raised a divide fault |
| swInt | input | 1 | Completed instruction was a software interrupt |
| swType | input | 8 | Type of the software interrupt |
| intoExec | input | 1 | Completed instruction was an overflow check |
| iretExec | input | 1 | Completed instruction was a return from interrupt |
| nmiPin | input | 1 | Non-maskable request, rising-edge sensitive |
| intrPin | input | 1 | Maskable request, level sensitive |
| intrType | input | 8 | Type supplied with the maskable request |
| curCs | input | 16 | Current code segment |
| nextIp | input | 16 | Address of the next instruction |
| ssBase | input | 16 | Stack segment |
| flagWr | input | 1 | Execution unit writes the flag word |
| flagWdata | input | 16 | Flag word to write |
| spWr | input | 1 | Execution unit writes SP |
| spWdata | input | 16 | SP value to write |
| memRdata | input | 16 | Read data, valid the cycle after a read request |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 20 | Physical byte address |
| memWdata | output | 16 | Write data |
| redirect | output | 1 | One-cycle pulse: fetch from newCs:newIp |
| newCs | output | 16 | Code segment to fetch from |
| newIp | output | 16 | Instruction pointer to fetch from |
| flagsOut | output | 16 | Current flag word |
| spOut | output | 16 | Current stack pointer |
| busy | output | 1 | A sequence is in progress |

## Verification
The hardest case to reach is the back-to-back entry. A non-maskable edge has to become pending only after the boundary decision has already picked the divide fault. The bench raises `nmiPin` in the same cycle as the `instrDone` pulse that carries the fault. The edge is then latched one cycle too late to compete, and it is found pending when the fault entry finishes. Single step is also delicate, because it depends on the trap flag as it stood one boundary earlier. The bench sets the flag between boundaries, expects nothing at the next boundary, and expects type 1 at the one after.

// File: rtl/int_entry_pkg.sv
package int_entry_pkg;

  localparam int TYPE_W = 8;

  localparam logic [TYPE_W-1:0] DIV_T  = 8'd0;
  localparam logic [TYPE_W-1:0] STEP_T = 8'd1;
  localparam logic [TYPE_W-1:0] NMI_T  = 8'd2;
  localparam logic [TYPE_W-1:0] INTO_T = 8'd4;

  typedef enum logic [1:0] {ADR_PUSH, ADR_POP, ADR_VLO, ADR_VHI} addrSel_e;
  typedef enum logic [1:0] {WD_FLAGS, WD_CS, WD_IP} wdSel_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic              idle;
    logic              memRd;
    logic              memWr;
    logic              spDec;
    logic              spInc;
    addrSel_e          addrSel;
    wdSel_e            wdSel;
    logic              clrIfTf;
    logic              capIp;
    logic              capCs;
    logic              capFlags;
    logic              latchRet;
    logic              chainRet;
    logic              loadType;
    logic [TYPE_W-1:0] typeVal;
    logic              clrNmi;
    logic              armTf;
    logic              redirect;
  } strobe_t;

endpackage

// File: rtl/int_entry_ctrl.sv
module int_entry_ctrl
  import int_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrDone,
  input  logic              divErr,
  input  logic              swInt,
  input  logic [TYPE_W-1:0] swType,
  input  logic              intoExec,
  input  logic              iretExec,
  input  logic              intrPin,
  input  logic [TYPE_W-1:0] intrType,
  input  logic              ifFlag,
  input  logic              ofFlag,
  input  logic              tfArm,
  input  logic              nmiPend,
  output strobe_t           st
);

  typedef enum logic [3:0] {
    S_IDLE, S_EFL, S_ECS, S_EIP, S_EVLO, S_EVHI, S_ELDCS,
    S_RIP, S_RCS, S_RFL, S_RLDF, S_FIN
  } state_e;

  state_e            stQ, stD;
  logic              entryQ, entryD;
  logic              take;
  logic [TYPE_W-1:0] tval;

  always_comb begin
    st     = '0;
    stD    = stQ;
    entryD = entryQ;
    take   = 1'b0;
    tval   = '0;
    case (stQ)
      S_IDLE: begin
        st.idle = 1'b1;
        if (instrDone) begin
          if (iretExec) begin
            stD    = S_RIP;
            entryD = 1'b0;
          end else begin
            take = 1'b1;
            // fixed priority: internal, NMI, INTR, single step
            if (divErr)                 tval = DIV_T;
            else if (swInt)             tval = swType;
            else if (intoExec && ofFlag) tval = INTO_T;
            else if (nmiPend) begin
              tval      = NMI_T;
              st.clrNmi = 1'b1;
            end
            else if (intrPin && ifFlag) tval = intrType;
            else if (tfArm)             tval = STEP_T;
            else                        take = 1'b0;
            if (take) begin
              st.latchRet = 1'b1;
              st.loadType = 1'b1;
              st.typeVal  = tval;
              stD         = S_EFL;
              entryD      = 1'b1;
            end else begin
              st.armTf = 1'b1;
            end
          end
        end
      end
      S_EFL: begin
        st.memWr = 1'b1; st.spDec = 1'b1; st.addrSel = ADR_PUSH;
        st.wdSel = WD_FLAGS; st.clrIfTf = 1'b1; stD = S_ECS;
      end
      S_ECS: begin
        st.memWr = 1'b1; st.spDec = 1'b1; st.addrSel = ADR_PUSH;
        st.wdSel = WD_CS; stD = S_EIP;
      end
      S_EIP: begin
        st.memWr = 1'b1; st.spDec = 1'b1; st.addrSel = ADR_PUSH;
        st.wdSel = WD_IP; stD = S_EVLO;
      end
      S_EVLO: begin
        st.memRd = 1'b1; st.addrSel = ADR_VLO; stD = S_EVHI;
      end
      S_EVHI: begin
        st.memRd = 1'b1; st.addrSel = ADR_VHI; st.capIp = 1'b1; stD = S_ELDCS;
      end
      S_ELDCS: begin
        st.capCs = 1'b1; stD = S_FIN;
      end
      S_RIP: begin
        st.memRd = 1'b1; st.spInc = 1'b1; st.addrSel = ADR_POP; stD = S_RCS;
      end
      S_RCS: begin
        st.memRd = 1'b1; st.spInc = 1'b1; st.addrSel = ADR_POP;
        st.capIp = 1'b1; stD = S_RFL;
      end
      S_RFL: begin
        st.memRd = 1'b1; st.spInc = 1'b1; st.addrSel = ADR_POP;
        st.capCs = 1'b1; stD = S_RLDF;
      end
      S_RLDF: begin
        st.capFlags = 1'b1; stD = S_FIN;
      end
      S_FIN: begin
        st.redirect = 1'b1;
        st.armTf    = 1'b1;
        // an NMI latched during an entry is taken before the handler runs
        if (entryQ && nmiPend) begin
          st.chainRet = 1'b1;
          st.loadType = 1'b1;
          st.typeVal  = NMI_T;
          st.clrNmi   = 1'b1;
          stD         = S_EFL;
        end else begin
          stD = S_IDLE;
        end
      end
      default: stD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ    <= S_IDLE;
      entryQ <= 1'b0;
    end else begin
      stQ    <= stD;
      entryQ <= entryD;
    end
  end

endmodule

// File: rtl/int_entry_dp.sv
module int_entry_dp
  import int_entry_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 20,
  parameter int TF_BIT   = 8,
  parameter int IF_BIT   = 9,
  parameter int OF_BIT   = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic          nmiPin,
  input  logic [DW-1:0] curCs,
  input  logic [DW-1:0] nextIp,
  input  logic [DW-1:0] ssBase,
  input  logic          flagWr,
  input  logic [DW-1:0] flagWdata,
  input  logic          spWr,
  input  logic [DW-1:0] spWdata,
  input  logic [DW-1:0] memRdata,
  output logic          ifFlag,
  output logic          ofFlag,
  output logic          tfArm,
  output logic          nmiPend,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [DW-1:0] newCs,
  output logic [DW-1:0] newIp,
  output logic [DW-1:0] flagsOut,
  output logic [DW-1:0] spOut
);

  localparam int SEG_SHIFT = 4;
  localparam int WORD_B    = DW / 8;
  localparam int VEC_SHIFT = 2;

  logic [DW-1:0]     flagsQ, flagsD, spQ, spMinus;
  logic [DW-1:0]     retCsQ, retIpQ, newCsQ, newIpQ;
  logic [TYPE_W-1:0] typeQ;
  logic              nmiPrevQ, nmiPendQ, tfArmQ;
  logic [AW-1:0]     stkBase, vecLo;

  always_comb begin
    flagsD = flagsQ;
    if (st.capFlags) flagsD = memRdata;
    else if (st.clrIfTf) begin
      flagsD[IF_BIT] = 1'b0;
      flagsD[TF_BIT] = 1'b0;
    end
    else if (flagWr && st.idle) flagsD = flagWdata;
  end

  assign spMinus = spQ - DW'(WORD_B);
  assign stkBase = AW'({ssBase, {SEG_SHIFT{1'b0}}});
  assign vecLo   = AW'({typeQ, {VEC_SHIFT{1'b0}}});

  always_comb begin
    case (st.addrSel)
      ADR_PUSH: memAddr = stkBase + AW'(spMinus);
      ADR_POP:  memAddr = stkBase + AW'(spQ);
      ADR_VLO:  memAddr = vecLo;
      default:  memAddr = vecLo + AW'(WORD_B);
    endcase
    case (st.wdSel)
      WD_FLAGS: memWdata = flagsQ;
      WD_CS:    memWdata = retCsQ;
      default:  memWdata = retIpQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ   <= '0;
      spQ      <= '0;
      retCsQ   <= '0;
      retIpQ   <= '0;
      newCsQ   <= '0;
      newIpQ   <= '0;
      typeQ    <= '0;
      nmiPrevQ <= 1'b0;
      nmiPendQ <= 1'b0;
      tfArmQ   <= 1'b0;
    end else begin
      flagsQ   <= flagsD;
      nmiPrevQ <= nmiPin;
      nmiPendQ <= (nmiPendQ && !st.clrNmi) || (nmiPin && !nmiPrevQ);
      if (st.armTf) tfArmQ <= flagsD[TF_BIT];
      if (st.spDec)             spQ <= spMinus;
      else if (st.spInc)        spQ <= spQ + DW'(WORD_B);
      else if (spWr && st.idle) spQ <= spWdata;
      if (st.latchRet) begin
        retCsQ <= curCs;
        retIpQ <= nextIp;
      end else if (st.chainRet) begin
        retCsQ <= newCsQ;
        retIpQ <= newIpQ;
      end
      if (st.loadType) typeQ  <= st.typeVal;
      if (st.capIp)    newIpQ <= memRdata;
      if (st.capCs)    newCsQ <= memRdata;
    end
  end

  assign ifFlag   = flagsQ[IF_BIT];
  assign ofFlag   = flagsQ[OF_BIT];
  assign tfArm    = tfArmQ;
  assign nmiPend  = nmiPendQ;
  assign newCs    = newCsQ;
  assign newIp    = newIpQ;
  assign flagsOut = flagsQ;
  assign spOut    = spQ;

endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
  import int_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrDone,
  input  logic        divErr,
  input  logic        swInt,
  input  logic [7:0]  swType,
  input  logic        intoExec,
  input  logic        iretExec,
  input  logic        nmiPin,
  input  logic        intrPin,
  input  logic [7:0]  intrType,
  input  logic [15:0] curCs,
  input  logic [15:0] nextIp,
  input  logic [15:0] ssBase,
  input  logic        flagWr,
  input  logic [15:0] flagWdata,
  input  logic        spWr,
  input  logic [15:0] spWdata,
  input  logic [15:0] memRdata,
  output logic        memReq,
  output logic        memWe,
  output logic [19:0] memAddr,
  output logic [15:0] memWdata,
  output logic        redirect,
  output logic [15:0] newCs,
  output logic [15:0] newIp,
  output logic [15:0] flagsOut,
  output logic [15:0] spOut,
  output logic        busy
);

  strobe_t st;
  logic    ifFlag, ofFlag, tfArm, nmiPend;

  int_entry_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .divErr(divErr),
    .swInt(swInt), .swType(swType), .intoExec(intoExec), .iretExec(iretExec),
    .intrPin(intrPin), .intrType(intrType), .ifFlag(ifFlag), .ofFlag(ofFlag),
    .tfArm(tfArm), .nmiPend(nmiPend), .st(st)
  );

  int_entry_dp #(.DW(16), .AW(20)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .nmiPin(nmiPin), .curCs(curCs),
    .nextIp(nextIp), .ssBase(ssBase), .flagWr(flagWr), .flagWdata(flagWdata),
    .spWr(spWr), .spWdata(spWdata), .memRdata(memRdata), .ifFlag(ifFlag),
    .ofFlag(ofFlag), .tfArm(tfArm), .nmiPend(nmiPend), .memAddr(memAddr),
    .memWdata(memWdata), .newCs(newCs), .newIp(newIp), .flagsOut(flagsOut),
    .spOut(spOut)
  );

  assign memReq   = st.memRd | st.memWr;
  assign memWe    = st.memWr;
  assign redirect = st.redirect;
  assign busy     = ~st.idle;

endmodule

// File: rtl/int_entry_chk.sv
module int_entry_chk #(
  parameter int TF_BIT = 8,
  parameter int IF_BIT = 9
) (
  input logic        clk,
  input logic        rstN,
  input logic        instrDone,
  input logic        busy,
  input logic        memReq,
  input logic        memWe,
  input logic        redirect,
  input logic [15:0] spOut,
  input logic [15:0] flagsOut
);

  // R2: memory traffic only inside a sequence
  a_r2_mem_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R2: a sequence starts only from a boundary pulse
  a_r2_start_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(instrDone));

  // R3: each push lowers SP by one word
  a_r3_push_dec_sp: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |=> (spOut == $past(spOut) - 16'd2));

  // R4: enable and trap flags stay clear once pushing has begun
  a_r4_flags_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |=> (!flagsOut[IF_BIT] && !flagsOut[TF_BIT]));

  // R5: redirect happens inside a sequence, with the memory port quiet
  a_r5_redirect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (busy && !memReq));

endmodule

bind int_entry_seq int_entry_chk chk_i (
  .clk(clk), .rstN(rstN), .instrDone(instrDone), .busy(busy),
  .memReq(memReq), .memWe(memWe), .redirect(redirect),
  .spOut(spOut), .flagsOut(flagsOut)
);

// File: tb/int_entry_seq_tb_top.sv
module int_entry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instrDone, divErr, swInt, intoExec, iretExec, nmiPin, intrPin;
  logic [7:0]  swType, intrType;
  logic [15:0] curCs, nextIp, ssBase, flagWdata, spWdata, memRdata;
  logic        flagWr, spWr;
  logic        memReq, memWe, redirect, busy;
  logic [19:0] memAddr;
  logic [15:0] memWdata, newCs, newIp, flagsOut, spOut;

  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  int_entry_seq dut_i (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .divErr(divErr),
    .swInt(swInt), .swType(swType), .intoExec(intoExec), .iretExec(iretExec),
    .nmiPin(nmiPin), .intrPin(intrPin), .intrType(intrType), .curCs(curCs),
    .nextIp(nextIp), .ssBase(ssBase), .flagWr(flagWr), .flagWdata(flagWdata),
    .spWr(spWr), .spWdata(spWdata), .memRdata(memRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .redirect(redirect),
    .newCs(newCs), .newIp(newIp), .flagsOut(flagsOut), .spOut(spOut), .busy(busy)
  );

  // memory model: vector table below 0x400 is computed, stack region is stored
  logic [15:0] stk [0:511];
  logic [15:0] rdQ = '0;
  logic [19:0] logA [0:127];
  logic [15:0] logD [0:127];
  int          logN = 0;

  function automatic logic [15:0] vecWord(logic [19:0] a);
    return a[1] ? (16'h2000 | {8'h00, a[9:2]}) : (16'h1000 | {8'h00, a[9:2]});
  endfunction

  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) begin
        stk[memAddr[9:1]]  <= memWdata;
        logA[logN[6:0]]    <= memAddr;
        logD[logN[6:0]]    <= memWdata;
        logN               <= logN + 1;
      end else begin
        rdQ <= (memAddr < 20'h400) ? vecWord(memAddr) : stk[memAddr[9:1]];
      end
    end
  end
  assign memRdata = rdQ;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    instrDone = 0; divErr = 0; swInt = 0; swType = 0; intoExec = 0; iretExec = 0;
    nmiPin = 0; intrPin = 0; intrType = 0; flagWr = 0; flagWdata = 0;
    spWr = 0; spWdata = 0; ssBase = 16'h0040; curCs = 16'h3000; nextIp = 16'h0500;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); spWr = 1; spWdata = 16'h0100;
    @(negedge clk); spWr = 0;
  endtask

  task automatic setFlags(logic [15:0] v);
    @(negedge clk); flagWr = 1; flagWdata = v;
    @(negedge clk); flagWr = 0;
  endtask

  task automatic boundary(logic d, logic s, logic [7:0] t, logic o, logic r);
    @(negedge clk);
    instrDone = 1; divErr = d; swInt = s; swType = t; intoExec = o; iretExec = r;
    @(negedge clk);
    instrDone = 0; divErr = 0; swInt = 0; intoExec = 0; iretExec = 0;
  endtask

  task automatic waitRedir(string req, logic [15:0] expCs, logic [15:0] expIp);
    bit seen = 0;
    logic [15:0] cs = '0, ip = '0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (redirect) begin seen = 1; cs = newCs; ip = newIp; end
    end
    chk(req, "redirect seen", 32'(seen), 32'd1);
    chk(req, "newCs", 32'(cs), 32'(expCs));
    chk(req, "newIp", 32'(ip), 32'(expIp));
  endtask

  task automatic quiet(string req, int n);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy || memReq) bad = 1;
    end
    chk(req, "stays idle", 32'(bad), 32'd0);
  endtask

  task automatic checkPush(string req, int base, logic [19:0] top,
                           logic [15:0] f, logic [15:0] cs, logic [15:0] ip);
    chk(req, "push0 addr", 32'(logA[base[6:0]]), 32'(top - 20'd2));
    chk(req, "push0 flags", 32'(logD[base[6:0]]), 32'(f));
    chk(req, "push1 addr", 32'(logA[7'(base + 1)]), 32'(top - 20'd4));
    chk(req, "push1 cs", 32'(logD[7'(base + 1)]), 32'(cs));
    chk(req, "push2 addr", 32'(logA[7'(base + 2)]), 32'(top - 20'd6));
    chk(req, "push2 ip", 32'(logD[7'(base + 2)]), 32'(ip));
  endtask

  task automatic tReset();
    doReset();
    chk("R1", "flags", 32'(flagsOut), 32'h0);
    chk("R1", "busy", 32'(busy), 32'h0);
    chk("R1", "memReq", 32'(memReq), 32'h0);
    chk("R1", "redirect", 32'(redirect), 32'h0);
  endtask

  task automatic tDivide();
    int base;
    doReset();
    setFlags(16'h0300);
    base = logN;
    boundary(1, 0, 8'h00, 0, 0);
    waitRedir("R5", 16'h2000, 16'h1000);
    chk("R3", "push count", 32'(logN - base), 32'd3);
    checkPush("R3", base, 20'h500, 16'h0300, 16'h3000, 16'h0500);
    chk("R4", "flags after entry", 32'(flagsOut), 32'h0);
    chk("R3", "sp after entry", 32'(spOut), 32'h00FA);
  endtask

  task automatic tSoftware();
    doReset();
    setFlags(16'h0200);
    intrPin = 1; intrType = 8'h40;
    boundary(0, 1, 8'h21, 0, 0);
    waitRedir("R6", 16'h2021, 16'h1021);
    intrPin = 0;
  endtask

  task automatic tOverflow();
    int base;
    doReset();
    boundary(0, 0, 8'h00, 1, 0);
    quiet("R9", 8);
    setFlags(16'h0800);
    base = logN;
    boundary(0, 0, 8'h00, 1, 0);
    waitRedir("R9", 16'h2004, 16'h1004);
    chk("R9", "pushed flags", 32'(logD[base[6:0]]), 32'h0800);
  endtask

  task automatic tNmi();
    doReset();
    setFlags(16'h0200);
    intrPin = 1; intrType = 8'h40;
    @(negedge clk); nmiPin = 1;
    repeat (2) @(negedge clk);
    boundary(0, 0, 8'h00, 0, 0);
    waitRedir("R6", 16'h2002, 16'h1002);
    boundary(0, 0, 8'h00, 0, 0);
    quiet("R7", 8);
    intrPin = 0;
    @(negedge clk); nmiPin = 0;
    @(negedge clk); nmiPin = 1;
    repeat (2) @(negedge clk);
    chk("R7", "IF off before second edge", 32'(flagsOut[9]), 32'd0);
    boundary(0, 0, 8'h00, 0, 0);
    waitRedir("R7", 16'h2002, 16'h1002);
    nmiPin = 0;
  endtask

  task automatic tIntr();
    int base;
    doReset();
    intrPin = 1; intrType = 8'h40;
    boundary(0, 0, 8'h00, 0, 0);
    quiet("R8", 6);
    setFlags(16'h0200);
    quiet("R2", 10);
    base = logN;
    boundary(0, 0, 8'h00, 0, 0);
    waitRedir("R8", 16'h2040, 16'h1040);
    chk("R8", "pushed flags", 32'(logD[base[6:0]]), 32'h0200);
    boundary(0, 0, 8'h00, 0, 0);
    quiet("R8", 6);
    boundary(0, 0, 8'h00, 0, 1);
    waitRedir("R10", 16'h3000, 16'h0500);
    @(negedge clk);
    chk("R10", "flags restored", 32'(flagsOut), 32'h0200);
    chk("R10", "sp restored", 32'(spOut), 32'h0100);
    boundary(0, 0, 8'h00, 0, 0);
    waitRedir("R8", 16'h2040, 16'h1040);
    intrPin = 0;
  endtask

  task automatic tChain();
    int base;
    doReset();
    base = logN;
    @(negedge clk); instrDone = 1; divErr = 1; nmiPin = 1;
    @(negedge clk); instrDone = 0; divErr = 0;
    waitRedir("R11", 16'h2000, 16'h1000);
    waitRedir("R11", 16'h2002, 16'h1002);
    checkPush("R11", base + 3, 20'h4FA, 16'h0000, 16'h2000, 16'h1000);
    chk("R11", "sp after two entries", 32'(spOut), 32'h00F4);
    nmiPin = 0;
  endtask

  task automatic tTrap();
    int base;
    doReset();
    setFlags(16'h0100);
    boundary(0, 0, 8'h00, 0, 0);
    quiet("R12", 6);
    base = logN;
    boundary(0, 0, 8'h00, 0, 0);
    waitRedir("R12", 16'h2001, 16'h1001);
    chk("R12", "pushed flags", 32'(logD[base[6:0]]), 32'h0100);
    chk("R12", "trap cleared", 32'(flagsOut), 32'h0);
  endtask

  task automatic tBusyWrites();
    doReset();
    boundary(1, 0, 8'h00, 0, 0);
    chk("R13", "busy during write", 32'(busy), 32'd1);
    flagWr = 1; flagWdata = 16'hFFFF; spWr = 1; spWdata = 16'h0000;
    @(negedge clk); flagWr = 0; spWr = 0;
    waitRedir("R13", 16'h2000, 16'h1000);
    chk("R13", "flags unchanged", 32'(flagsOut), 32'h0);
    chk("R13", "sp unchanged", 32'(spOut), 32'h00FA);
  endtask

  initial begin
    tReset();
    tDivide();
    tSoftware();
    tOverflow();
    tNmi();
    tIntr();
    tChain();
    tTrap();
    tBusyWrites();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule